// File: doc/BRIEF.md
# NAND raw page read sequencer

This block performs one raw read from a NAND flash page and returns a single byte taken at a column that the caller picks. The usual use is to fetch the bad-block marker from the spare area of the first page of a block before the block is trusted. The caller supplies a row (page) number, a column, and a configuration bit that selects a two-byte or a three-byte row address. A single-cycle start pulse then begins the transaction.

The sequencer first clears its interrupt status. It then drives the read-setup command, two column bytes, the row bytes and the read-confirm command onto an 8-bit bus, each with its own strobe. Next it waits for the device-ready event to appear as the interrupt-active status bit. It then strobes one data fetch and reports the byte with a one-cycle done pulse. The ECC enable output is held low for the whole access. If the ready bit does not arrive within a parameterised number of cycles, the sequencer raises an error flag and returns to idle without a done pulse.

Top module: `nand_rawrd_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `ecc_en_o`=1, all strobes low, `bus_o`=0, `sts_o`=0, `err_o`=0, `done_o`=0 and `byte_o`=0.
- R2: An accepted start spends one cycle clearing the status register. The first bus cycle is then the command byte 0x00 on `cmd_stb_o`, followed by two address cycles on `addr_stb_o` that carry the column low byte and then the column high byte.
- R3: The row address follows the column bytes, low byte first. It is two address cycles (row bits 7:0, 15:8) when `two_row_i` was 1 at start, and three (adding bits 23:16) when it was 0.
- R4: The last bus cycle is the command byte 0x30 on `cmd_stb_o`, after which the block waits for the ready status.
- R5: Each command or address byte keeps its strobe high and its value on `bus_o` for exactly HOLD_CYC cycles, followed by one cycle with all strobes low and `bus_o`=0. At most one of the three strobes is high in any cycle.
- R6: `rd_stb_o` stays low until a wait-phase cycle sees `sts_o[12]`=1. It rises in the next cycle, is held for HOLD_CYC cycles, and `data_i` is captured in the last of them.
- R7: One cycle after the fetch ends, `done_o` is high for exactly one cycle, and `byte_o` holds the captured byte from then on.
- R8: `sts_o[12]` (interrupt active) is set in the cycle after `ready_i`=1. A host write with `sts_wr_i`=1 clears it when `sts_wdata_i[12]`=1 and leaves it unchanged when that bit is 0. The start-of-transaction clear also clears it. A set in the same cycle as a clear wins. All other status bits read 0.
- R9: `ecc_en_o` is 0 in every cycle in which the block is busy and 1 while idle.
- R10: `busy_o` is 1 from the cycle after an accepted start until the cycle after the done or error cycle. A start while busy is ignored, including any change of `row_i`, `col_i` or `two_row_i`.
- R11: If `sts_o[12]` is not seen within TMO_CYC wait cycles, `err_o` becomes 1 as the block returns to idle, and no done pulse or fetch strobe occurs. `err_o` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| row_i | input | 24 | Page (row) number |
| col_i | input | 16 | Column of the byte to return |
| two_row_i | input | 1 | 1 = two row address bytes, 0 = three |
| data_i | input | 8 | Data byte from the device |
| ready_i | input | 1 | Device ready event, sets interrupt-active status |
| sts_wr_i | input | 1 | Host write strobe to the status register |
| sts_wdata_i | input | 16 | Write-one-to-clear mask |
| bus_o | output | 8 | Command / address byte |
| cmd_stb_o | output | 1 | Command cycle strobe |
| addr_stb_o | output | 1 | Address cycle strobe |
| rd_stb_o | output | 1 | Data fetch strobe |
| busy_o | output | 1 | Transaction in progress |
| ecc_en_o | output | 1 | ECC enable, low during the raw access |
| done_o | output | 1 | One-cycle completion pulse |
| byte_o | output | 8 | Last fetched byte |
| err_o | output | 1 | Ready timeout flag |
| sts_o | output | 16 | Interrupt status, bit 12 = interrupt active |

## Verification
The assertions check several rules on every clock. They confirm that the strobes are mutually exclusive, that ECC is off while any strobe is active, and that the fetch never starts in the cycle after a wait cycle without the ready bit. They also check the one-cycle done pulse, that a set status bit wins over a clear, that the latched request does not change while busy, and that an error appears only as the block goes idle. Only the bench scenarios can show the exact byte order and values on the bus, the two- versus three-byte row choice, the hold length of each byte, and that an early ready event skips the wait. The same holds for the status being cleared at start and the timeout firing after exactly the configured wait.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
    localparam int COL_W       = 16;
    localparam int ROW_W       = 24;
    localparam int STS_W       = 16;
    localparam int STS_INT_ACT = 12;
    localparam int IDX_W       = 3;

    localparam logic [7:0] CMD_SETUP   = 8'h00;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;

    typedef enum logic [2:0] {
        S_IDLE, S_CLR, S_EMIT, S_GAP, S_WAIT, S_FETCH, S_DONE
    } st_e;

    typedef enum logic [1:0] {K_NONE, K_CMD, K_ADDR} kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] val;
    } cyc_t;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             two_row;
    } req_t;

    // index of the final (confirm) cycle in the bus sequence
    function automatic logic [IDX_W-1:0] last_idx(input logic two_row);
        return two_row ? IDX_W'(5) : IDX_W'(6);
    endfunction

    // bus cycle for a given position in the sequence
    function automatic cyc_t item_at(input logic [IDX_W-1:0] idx, input req_t r);
        cyc_t c;
        c.kind = K_ADDR;
        c.val  = 8'h00;
        case (idx)
            3'd0: begin c.kind = K_CMD; c.val = CMD_SETUP; end
            3'd1: c.val = r.col[7:0];
            3'd2: c.val = r.col[15:8];
            3'd3: c.val = r.row[7:0];
            3'd4: c.val = r.row[15:8];
            3'd5: begin
                if (r.two_row) begin c.kind = K_CMD; c.val = CMD_CONFIRM; end
                else           c.val = r.row[23:16];
            end
            default: begin c.kind = K_CMD; c.val = CMD_CONFIRM; end
        endcase
        return c;
    endfunction
endpackage

// File: rtl/nrr_cnt.sv
module nrr_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic last_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)              cnt <= '0;
        else if (en && cnt != TOP)   cnt <= cnt + 1'b1;
    end

    assign last_o = (cnt == TOP);

    // R5 / R11: counter never passes its terminal value
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && last_o) |=> last_o || $past(clr));
endmodule

// File: rtl/nrr_irq_sts.sv
module nrr_irq_sts
    import nrr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  logic             hw_clr_i,
    input  logic             wr_i,
    input  logic [STS_W-1:0] wdata_i,
    output logic [STS_W-1:0] sts_o
);
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;
    logic [STS_W-1:0] sts_q;

    assign set_vec = set_i ? (STS_W'(1) << STS_INT_ACT) : '0;
    assign clr_vec = (hw_clr_i ? '1 : '0) | (wr_i ? wdata_i : '0);

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= set_vec | (sts_q & ~clr_vec);
    end

    assign sts_o = sts_q;

    // R8: a ready event always leaves the bit set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> sts_o[STS_INT_ACT]);
    // R8: write-one clears when no concurrent set
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[STS_INT_ACT] && !set_i) |=> !sts_o[STS_INT_ACT]);
endmodule

// File: rtl/nand_rawrd_seq.sv
module nand_rawrd_seq
    import nrr_pkg::*;
#(
    parameter int HOLD_CYC = 2,
    parameter int TMO_CYC  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             two_row_i,
    input  logic [7:0]       data_i,
    input  logic             ready_i,
    input  logic             sts_wr_i,
    input  logic [STS_W-1:0] sts_wdata_i,
    output logic [7:0]       bus_o,
    output logic             cmd_stb_o,
    output logic             addr_stb_o,
    output logic             rd_stb_o,
    output logic             busy_o,
    output logic             ecc_en_o,
    output logic             done_o,
    output logic [7:0]       byte_o,
    output logic             err_o,
    output logic [STS_W-1:0] sts_o
);
    st_e              state;
    req_t             req_q;
    logic [IDX_W-1:0] idx;
    logic [7:0]       byte_q;
    logic             err_q;
    cyc_t             cur;
    logic             hold_run, hold_last, tmo_last;
    logic [STS_W-1:0] sts_w;

    assign hold_run = (state == S_EMIT) || (state == S_FETCH);

    nrr_cnt #(.LIMIT(HOLD_CYC)) u_hold (
        .clk(clk), .rst(rst),
        .clr(!hold_run || hold_last), .en(hold_run),
        .last_o(hold_last)
    );

    nrr_cnt #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst(rst),
        .clr(state != S_WAIT), .en(state == S_WAIT),
        .last_o(tmo_last)
    );

    nrr_irq_sts u_sts (
        .clk(clk), .rst(rst),
        .set_i(ready_i), .hw_clr_i(state == S_CLR),
        .wr_i(sts_wr_i), .wdata_i(sts_wdata_i),
        .sts_o(sts_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            req_q  <= '0;
            idx    <= '0;
            byte_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    req_q <= '{col: col_i, row: row_i, two_row: two_row_i};
                    err_q <= 1'b0;
                    state <= S_CLR;
                end
                S_CLR: begin
                    idx   <= '0;
                    state <= S_EMIT;
                end
                S_EMIT: if (hold_last) state <= S_GAP;
                S_GAP: begin
                    if (idx == last_idx(req_q.two_row)) state <= S_WAIT;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_EMIT;
                    end
                end
                S_WAIT: begin
                    if (sts_w[STS_INT_ACT]) state <= S_FETCH;
                    else if (tmo_last) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_FETCH: if (hold_last) begin
                    byte_q <= data_i;
                    state  <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cur        = item_at(idx, req_q);
    assign cmd_stb_o  = (state == S_EMIT) && (cur.kind == K_CMD);
    assign addr_stb_o = (state == S_EMIT) && (cur.kind == K_ADDR);
    assign bus_o      = (state == S_EMIT) ? cur.val : 8'h00;
    assign rd_stb_o   = (state == S_FETCH);
    assign busy_o     = (state != S_IDLE);
    assign ecc_en_o   = !busy_o;
    assign done_o     = (state == S_DONE);
    assign byte_o     = byte_q;
    assign err_o      = err_q;
    assign sts_o      = sts_w;

    // R5: strobes never overlap
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb_o, addr_stb_o, rd_stb_o}));
    // R9: ECC is off whenever the bus is active
    a_r9_ecc_off: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb_o || addr_stb_o || rd_stb_o) |-> !ecc_en_o);
    // R6: no fetch after a wait cycle without ready
    a_r6_fetch_gated: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !sts_w[STS_INT_ACT]) |=> !rd_stb_o);
    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R10: a start while busy does not disturb the latched request
    a_r10_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(req_q));
    // R11: error appears only as the block goes idle
    a_r11_err_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> !busy_o);
endmodule

// File: tb/nand_rawrd_seq_test.sv
module nand_rawrd_seq_test;
    localparam int HOLD = 3;
    localparam int TMO  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] row_i = '0;
    logic [15:0] col_i = '0;
    logic        two_row_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        ready_i = 1'b0;
    logic        sts_wr_i = 1'b0;
    logic [15:0] sts_wdata_i = '0;
    logic [7:0]  bus_o;
    logic        cmd_stb_o, addr_stb_o, rd_stb_o, busy_o, ecc_en_o, done_o, err_o;
    logic [7:0]  byte_o;
    logic [15:0] sts_o;

    nand_rawrd_seq #(.HOLD_CYC(HOLD), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .row_i(row_i), .col_i(col_i),
        .two_row_i(two_row_i), .data_i(data_i), .ready_i(ready_i),
        .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .bus_o(bus_o),
        .cmd_stb_o(cmd_stb_o), .addr_stb_o(addr_stb_o), .rd_stb_o(rd_stb_o),
        .busy_o(busy_o), .ecc_en_o(ecc_en_o), .done_o(done_o), .byte_o(byte_o),
        .err_o(err_o), .sts_o(sts_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // ph: 0 idle, 1 clear, 2 bus cycles, 3 wait, 4 fetch, 5 done
    int          ph = 0;
    int          q[$];
    string       tq[$];
    bit          m_sts = 0;
    bit          m_err = 0;
    logic [7:0]  m_byte = '0;
    int          wcnt = 0;
    int          fcnt = 0;

    task automatic push_byte(input int kind, input logic [7:0] v, input string tag);
        for (int i = 0; i < HOLD; i++) begin
            q.push_back(kind * 256 + int'(v));
            tq.push_back(tag);
        end
        q.push_back(0);
        tq.push_back("R5");
    endtask

    task automatic build(input logic [15:0] c, input logic [23:0] r, input bit two);
        q.delete();
        tq.delete();
        push_byte(1, 8'h00, "R2");
        push_byte(2, c[7:0], "R2");
        push_byte(2, c[15:8], "R2");
        push_byte(2, r[7:0], "R3");
        push_byte(2, r[15:8], "R3");
        if (!two) push_byte(2, r[23:16], "R3");
        push_byte(1, 8'h30, "R4");
    endtask

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; q.delete(); tq.delete();
            m_sts = 0; m_err = 0; m_byte = '0; wcnt = 0; fcnt = 0;
        end else begin
            bit old_sts;
            old_sts = m_sts;
            if (ready_i) m_sts = 1;
            else if (ph == 1 || (sts_wr_i && sts_wdata_i[12])) m_sts = 0;
            case (ph)
                0: if (start_i) begin build(col_i, row_i, two_row_i); m_err = 0; ph = 1; end
                1: ph = 2;
                2: begin
                    void'(q.pop_front());
                    void'(tq.pop_front());
                    if (q.size() == 0) begin ph = 3; wcnt = 0; end
                end
                3: begin
                    if (old_sts) begin ph = 4; fcnt = 0; end
                    else if (wcnt == TMO - 1) begin ph = 0; m_err = 1; end
                    else wcnt++;
                end
                4: begin
                    if (fcnt == HOLD - 1) begin m_byte = data_i; ph = 5; end
                    else fcnt++;
                end
                default: ph = 0;
            endcase
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int    e;
            string tag;
            e   = (ph == 2) ? q[0] : 0;
            tag = (ph == 2) ? tq[0] : ((ph == 4) ? "R6" : "R5");
            check(tag, {21'd0, cmd_stb_o, addr_stb_o, rd_stb_o, bus_o},
                  {21'd0, (e / 256) == 1, (e / 256) == 2, ph == 4, 8'(e % 256)});
            check("R10 busy", {31'd0, busy_o}, {31'd0, ph != 0});
            check("R9 ecc", {31'd0, ecc_en_o}, {31'd0, ph == 0});
            check("R7 done/byte", {23'd0, done_o, byte_o}, {23'd0, ph == 5, m_byte});
            check("R11 err", {31'd0, err_o}, {31'd0, m_err});
            check("R8 status", {16'd0, sts_o}, {16'd0, 16'(m_sts) << 12});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // one transaction; rdy_at < 0 means no ready event
    task automatic run_txn(input logic [15:0] c, input logic [23:0] r, input bit two,
                           input logic [7:0] d, input int rdy_at, input bit poke);
        @(negedge clk);
        col_i = c; row_i = r; two_row_i = two; data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy_o) break;
            ready_i = (i == rdy_at);
            start_i = poke && (i == 3 || i == 30);
            if (poke && i == 3) begin col_i = 16'hFFFF; row_i = 24'hFFFFFF; two_row_i = ~two; end
        end
        ready_i = 1'b0;
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 ecc", {31'd0, ecc_en_o}, 32'd1);
        check("R1 strobes/bus", {21'd0, cmd_stb_o, addr_stb_o, rd_stb_o, bus_o}, 32'd0);
        check("R1 sts/err/byte", {7'd0, sts_o, err_o, byte_o}, 32'd0);

        // three-byte row, ready during wait, marker byte 0xFF
        run_txn(16'h0840, 24'h012345, 1'b0, 8'hFF, 26, 1'b0);
        check("R7 byte three-row", {24'd0, byte_o}, 32'h0000_00FF);

        // two-byte row, starts while busy ignored
        run_txn(16'h1000, 24'h00ABCD, 1'b1, 8'h00, 24, 1'b1);
        check("R10 byte after ignored start", {24'd0, byte_o}, 32'd0);

        // R8: host write-one-to-clear behaviour while idle
        @(negedge clk); ready_i = 1'b1;
        @(negedge clk); ready_i = 1'b0;
        check("R8 set by ready", {16'd0, sts_o}, 32'h0000_1000);
        sts_wr_i = 1'b1; sts_wdata_i = 16'hEFFF;
        @(negedge clk); sts_wr_i = 1'b0;
        check("R8 write zero keeps", {16'd0, sts_o}, 32'h0000_1000);
        sts_wr_i = 1'b1; sts_wdata_i = 16'h1000; ready_i = 1'b1;
        @(negedge clk); ready_i = 1'b0;
        check("R8 set wins over clear", {16'd0, sts_o}, 32'h0000_1000);
        @(negedge clk); sts_wr_i = 1'b0;
        check("R8 write one clears", {16'd0, sts_o}, 32'd0);

        // R2: stale status is cleared at start; no ready -> R11 timeout
        @(negedge clk); ready_i = 1'b1;
        @(negedge clk); ready_i = 1'b0;
        run_txn(16'h0200, 24'h000040, 1'b1, 8'h5A, -1, 1'b0);
        check("R11 timeout flag", {31'd0, err_o}, 32'd1);
        check("R11 byte unchanged", {24'd0, byte_o}, 32'd0);

        // early ready during bus cycles: fetch right after confirm; clears err
        run_txn(16'h00FF, 24'hC0FFEE, 1'b0, 8'h3C, 5, 1'b0);
        check("R11 err cleared by start", {31'd0, err_o}, 32'd0);
        check("R6 early ready byte", {24'd0, byte_o}, 32'h0000_003C);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule